// File: doc/BRIEF.md
# PAL Progressive Composite Sync Generator

This block produces a single active-low composite sync waveform for a non-interlaced, single-field PAL frame of about 50 Hz. Every timing comes from counters running on one fixed reference clock. At the default of 80 cycles per microsecond, a half-line is 2560 cycles and a full line is 5120 cycles. Each frame opens with a vertical interval of half-line slots. The first slots carry short equalising pulses, the middle slots carry broad pulses, and the closing slots carry equalising pulses again. A run of full lines follows, each starting with a normal line-sync pulse.

Next to the sync level, the block reports the current line number, a flag that is high only inside the picture window of a picture line, and a one-clock frame-start pulse. A downstream pixel streamer uses these three outputs to time its data. The line number counts down from the number of lines in the frame to one and reads zero during the vertical interval. When the enable input is low, the generator is parked at the start of the frame and the sync output is held high.

Top module: `pal_comp_sync`

## Requirements
- R1: While reset is asserted or the block is disabled, sync_n_o is 1, line_active_o is 0, frame_start_o is 0 and line_num_o is 0.
- R2: A frame starts with N_PRE + N_BROAD + N_POST half-line slots, each HALF_CYC cycles long. The first N_PRE slots are equalising, the next N_BROAD are broad, and the last N_POST are equalising. The first slot begins at the first cycle of operation.
- R3: In an equalising slot, sync_n_o is 0 for the first EQ_CYC cycles and 1 for the rest of the slot.
- R4: In a broad slot, sync_n_o is 0 for the first HALF_CYC - EQ_CYC cycles and 1 for the last EQ_CYC cycles.
- R5: The vertical slots are followed by N_LINES lines of LINE_CYC cycles each. Each line starts with HS_CYC cycles of sync_n_o = 0, and sync_n_o is 1 for the rest of the line. Falling edges of sync are therefore LINE_CYC cycles apart.
- R6: line_num_o reads N_LINES on the first line and decreases by one at each line boundary, down to 1. It reads 0 in the vertical slots. After line 1, the vertical slots start again.
- R7: frame_start_o is 1 for exactly the first cycle of line N_LINES, once per frame.
- R8: line_active_o is 1 only on lines whose number lies in ACT_LO..ACT_HI inclusive. On those lines it is 1 from cycle HS_CYC + PORCH_CYC through cycle HS_CYC + PORCH_CYC + PIC_CYC - 1, counted from the line start.
- R9: If en_i is sampled low on a clock edge, the outputs take the disabled values of R1 after that edge. When en_i is sampled high again, the cycle after that edge is the first cycle of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; when low, the generator is parked at frame start |
| sync_n_o | output | 1 | Composite sync, active low |
| line_active_o | output | 1 | High inside the picture window of a picture line |
| frame_start_o | output | 1 | One-cycle pulse at the start of the first line |
| line_num_o | output | LN_W | Current line number, 0 in the vertical slots |

## Verification
A wrong slot index or slot kind shows up at sync_n_o within one half-line: a broad pulse stays low where an equalising pulse should already have returned high. A wrong cycle counter moves a sync edge and breaks the spacing between edges on the very next slot. A wrong line counter shows first as a wrong line_num_o value at a line boundary. It then shows as a shifted picture window or a misplaced frame_start_o, and by the end of the frame the vertical slots start on the wrong cycle. The bench compares every output on every cycle against a frame model built only from the cycle arithmetic in the requirements, so any such error is caught at the first cycle where it differs.

// File: rtl/pal_sync_pkg.sv
package pal_sync_pkg;
  typedef enum logic {PH_VERT = 1'b0, PH_LINE = 1'b1} phase_e;
  typedef enum logic {SK_EQ = 1'b0, SK_BROAD = 1'b1} slot_kind_e;
endpackage

// File: rtl/pal_slot_timer.sv
module pal_slot_timer #(
  parameter int CYC_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CYC_W-1:0] len_i,
  output logic [CYC_W-1:0] cyc_o,
  output logic             last_o
);
  logic [CYC_W-1:0] cyc_q;

  assign last_o = run_i && (cyc_q == len_i - 1'b1);
  assign cyc_o  = cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cyc_q <= '0;
    else if (!run_i)  cyc_q <= '0;
    else if (last_o)  cyc_q <= '0;
    else              cyc_q <= cyc_q + 1'b1;
  end
endmodule

// File: rtl/pal_frame_seq.sv
module pal_frame_seq
  import pal_sync_pkg::*;
#(
  parameter int N_VSLOT = 16,
  parameter int N_LINES = 304,
  parameter int SLOT_W  = 4,
  parameter int LN_W    = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              last_i,
  output phase_e            phase_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [LN_W-1:0]   line_o
);
  localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(N_VSLOT - 1);
  localparam logic [LN_W-1:0]   LN_TOP   = LN_W'(N_LINES);
  localparam logic [LN_W-1:0]   LN_ONE   = LN_W'(1);

  phase_e            phase_q;
  logic [SLOT_W-1:0] slot_q;
  logic [LN_W-1:0]   line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_VERT;
      slot_q  <= '0;
      line_q  <= '0;
    end else if (!run_i) begin
      phase_q <= PH_VERT;
      slot_q  <= '0;
      line_q  <= '0;
    end else if (last_i) begin
      if (phase_q == PH_VERT) begin
        if (slot_q == SLOT_END) begin
          phase_q <= PH_LINE;
          slot_q  <= '0;
          line_q  <= LN_TOP;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end else begin
        if (line_q == LN_ONE) begin
          phase_q <= PH_VERT;
          line_q  <= '0;
        end else begin
          line_q <= line_q - 1'b1;
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign slot_o  = slot_q;
  assign line_o  = line_q;
endmodule

// File: rtl/pal_wave_decode.sv
module pal_wave_decode
  import pal_sync_pkg::*;
#(
  parameter int CYC_W     = 13,
  parameter int LN_W      = 9,
  parameter int HALF_CYC  = 2560,
  parameter int EQ_CYC    = 160,
  parameter int HS_CYC    = 320,
  parameter int PORCH_CYC = 640,
  parameter int PIC_CYC   = 4000,
  parameter int N_LINES   = 304,
  parameter int ACT_LO    = 26,
  parameter int ACT_HI    = 259
) (
  input  logic             run_i,
  input  phase_e           phase_i,
  input  slot_kind_e       kind_i,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic [LN_W-1:0]  line_i,
  output logic             sync_n_o,
  output logic             active_o,
  output logic             fstart_o
);
  localparam logic [CYC_W-1:0] EQ_END   = CYC_W'(EQ_CYC);
  localparam logic [CYC_W-1:0] BR_END   = CYC_W'(HALF_CYC - EQ_CYC);
  localparam logic [CYC_W-1:0] HS_END   = CYC_W'(HS_CYC);
  localparam logic [CYC_W-1:0] PIC_BEG  = CYC_W'(HS_CYC + PORCH_CYC);
  localparam logic [CYC_W-1:0] PIC_END  = CYC_W'(HS_CYC + PORCH_CYC + PIC_CYC);
  localparam logic [LN_W-1:0]  LN_LO    = LN_W'(ACT_LO);
  localparam logic [LN_W-1:0]  LN_HI    = LN_W'(ACT_HI);
  localparam logic [LN_W-1:0]  LN_TOP   = LN_W'(N_LINES);

  logic low_c, pic_line_c, pic_win_c;

  always_comb begin
    if (phase_i == PH_VERT)
      low_c = (kind_i == SK_BROAD) ? (cyc_i < BR_END) : (cyc_i < EQ_END);
    else
      low_c = cyc_i < HS_END;
  end

  assign pic_line_c = (phase_i == PH_LINE) && (line_i >= LN_LO) && (line_i <= LN_HI);
  assign pic_win_c  = (cyc_i >= PIC_BEG) && (cyc_i < PIC_END);

  assign sync_n_o = !(run_i && low_c);
  assign active_o = run_i && pic_line_c && pic_win_c;
  assign fstart_o = run_i && (phase_i == PH_LINE) && (line_i == LN_TOP) && (cyc_i == '0);
endmodule

// File: rtl/pal_comp_sync.sv
module pal_comp_sync
  import pal_sync_pkg::*;
#(
  parameter int HALF_CYC  = 2560,
  parameter int LINE_CYC  = 5120,
  parameter int EQ_CYC    = 160,
  parameter int HS_CYC    = 320,
  parameter int PORCH_CYC = 640,
  parameter int PIC_CYC   = 4000,
  parameter int N_PRE     = 6,
  parameter int N_BROAD   = 5,
  parameter int N_POST    = 5,
  parameter int N_LINES   = 304,
  parameter int ACT_LO    = 26,
  parameter int ACT_HI    = 259,
  localparam int LN_W     = $clog2(N_LINES + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  output logic            sync_n_o,
  output logic            line_active_o,
  output logic            frame_start_o,
  output logic [LN_W-1:0] line_num_o
);
  localparam int N_VSLOT = N_PRE + N_BROAD + N_POST;
  localparam int CYC_W   = $clog2(LINE_CYC + 1);
  localparam int SLOT_W  = (N_VSLOT > 1) ? $clog2(N_VSLOT) : 1;
  localparam logic [CYC_W-1:0] HALF_LEN = CYC_W'(HALF_CYC);
  localparam logic [CYC_W-1:0] LINE_LEN = CYC_W'(LINE_CYC);

  logic              run_q;
  logic [CYC_W-1:0]  cyc;
  logic              last;
  phase_e            phase;
  logic [SLOT_W-1:0] slot;
  logic [LN_W-1:0]   line;
  logic [N_VSLOT-1:0] broad_map;
  slot_kind_e        kind;
  logic [CYC_W-1:0]  len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i;
  end

  // slot kind lookup built from the three run lengths
  for (genvar gi = 0; gi < N_VSLOT; gi++) begin : g_kind
    assign broad_map[gi] = (gi >= N_PRE) && (gi < N_PRE + N_BROAD);
  end

  assign kind = broad_map[slot] ? SK_BROAD : SK_EQ;
  assign len  = (phase == PH_VERT) ? HALF_LEN : LINE_LEN;

  pal_slot_timer #(.CYC_W(CYC_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .len_i  (len),
    .cyc_o  (cyc),
    .last_o (last)
  );

  pal_frame_seq #(
    .N_VSLOT (N_VSLOT),
    .N_LINES (N_LINES),
    .SLOT_W  (SLOT_W),
    .LN_W    (LN_W)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .last_i  (last),
    .phase_o (phase),
    .slot_o  (slot),
    .line_o  (line)
  );

  pal_wave_decode #(
    .CYC_W     (CYC_W),
    .LN_W      (LN_W),
    .HALF_CYC  (HALF_CYC),
    .EQ_CYC    (EQ_CYC),
    .HS_CYC    (HS_CYC),
    .PORCH_CYC (PORCH_CYC),
    .PIC_CYC   (PIC_CYC),
    .N_LINES   (N_LINES),
    .ACT_LO    (ACT_LO),
    .ACT_HI    (ACT_HI)
  ) u_dec (
    .run_i    (run_q),
    .phase_i  (phase),
    .kind_i   (kind),
    .cyc_i    (cyc),
    .line_i   (line),
    .sync_n_o (sync_n_o),
    .active_o (line_active_o),
    .fstart_o (frame_start_o)
  );

  assign line_num_o = run_q ? line : '0;
endmodule

// File: rtl/pal_comp_sync_chk.sv
module pal_comp_sync_chk #(
  parameter int HALF_CYC = 2560,
  parameter int EQ_CYC   = 160,
  parameter int N_LINES  = 304,
  parameter int ACT_LO   = 26,
  parameter int ACT_HI   = 259,
  parameter int LN_W     = 9
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            sync_n_o,
  input logic            line_active_o,
  input logic            frame_start_o,
  input logic [LN_W-1:0] line_num_o
);
  localparam int LOW_W = $clog2(HALF_CYC + 2);
  localparam logic [LOW_W-1:0] LOW_MAX = LOW_W'(HALF_CYC - EQ_CYC);
  logic [LOW_W-1:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_run_q <= '0;
    else if (sync_n_o) low_run_q <= '0;
    else if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
  end

  AST_LOW_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_run_q <= LOW_MAX); // R4

  AST_FSTART_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o); // R7

  AST_FSTART_TOP_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (line_num_o == LN_W'(N_LINES))); // R7

  AST_ACTIVE_SYNC_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_active_o |-> sync_n_o); // R8

  AST_ACTIVE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_active_o |-> (line_num_o >= LN_W'(ACT_LO) && line_num_o <= LN_W'(ACT_HI))); // R8

  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_num_o != $past(line_num_o)) |->
      (line_num_o == $past(line_num_o) - 1'b1 || line_num_o == LN_W'(N_LINES) || line_num_o == '0)); // R6

  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (sync_n_o && !line_active_o && !frame_start_o && line_num_o == '0)); // R9
endmodule

bind pal_comp_sync pal_comp_sync_chk #(
  .HALF_CYC (HALF_CYC),
  .EQ_CYC   (EQ_CYC),
  .N_LINES  (N_LINES),
  .ACT_LO   (ACT_LO),
  .ACT_HI   (ACT_HI),
  .LN_W     (LN_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .sync_n_o      (sync_n_o),
  .line_active_o (line_active_o),
  .frame_start_o (frame_start_o),
  .line_num_o    (line_num_o)
);

// File: tb/pal_comp_sync_tb_top.sv
`timescale 1ns/1ps
module pal_comp_sync_tb_top;
  localparam int HALF = 40, LINE = 80, EQ = 4, HS = 8, PORCH = 10, PIC = 50;
  localparam int NPRE = 6, NBR = 5, NPOST = 5, NL = 30, LO = 5, HI = 20;
  localparam int VS = NPRE + NBR + NPOST;
  localparam int VCYC = VS * HALF;
  localparam int FRAME = VCYC + NL * LINE;
  localparam int LN_W = $clog2(NL + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b1;
  logic sync_n_o, line_active_o, frame_start_o;
  logic [LN_W-1:0] line_num_o;

  int total = 0, bad = 0, t = 0;
  int m_sync, m_act, m_line, m_fs, first_t, last_fall, fall_bad, fs_cnt;
  int a_sync, e_sync, a_act, e_act, a_line, e_line, a_fs, e_fs;
  int gap_a, gap_e;

  always #2 clk_i = ~clk_i;

  pal_comp_sync #(
    .HALF_CYC(HALF), .LINE_CYC(LINE), .EQ_CYC(EQ), .HS_CYC(HS), .PORCH_CYC(PORCH),
    .PIC_CYC(PIC), .N_PRE(NPRE), .N_BROAD(NBR), .N_POST(NPOST), .N_LINES(NL),
    .ACT_LO(LO), .ACT_HI(HI)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sync_n_o(sync_n_o),
    .line_active_o(line_active_o), .frame_start_o(frame_start_o), .line_num_o(line_num_o)
  );

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected outputs at cycle tt since start of operation
  task automatic model(input int tt, output int es, output int ea, output int el, output int ef);
    int u, s, c, li;
    u = tt % FRAME;
    ea = 0; ef = 0; el = 0;
    if (u < VCYC) begin
      s = u / HALF; c = u % HALF;
      if (s >= NPRE && s < NPRE + NBR) es = (c < HALF - EQ) ? 0 : 1;
      else es = (c < EQ) ? 0 : 1;
    end else begin
      li = (u - VCYC) / LINE; c = (u - VCYC) % LINE;
      el = NL - li;
      es = (c < HS) ? 0 : 1;
      ea = (el >= LO && el <= HI && c >= HS + PORCH && c < HS + PORCH + PIC) ? 1 : 0;
      ef = (li == 0 && c == 0) ? 1 : 0;
    end
  endtask

  task automatic clear_stats();
    m_sync = 0; m_act = 0; m_line = 0; m_fs = 0; fall_bad = 0; fs_cnt = 0;
    last_fall = -1; first_t = -1;
  endtask

  // compare n cycles, sampling at negedge
  task automatic compare_run(input int n);
    int es, ea, el, ef;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      model(t, es, ea, el, ef);
      if (sync_n_o !== es[0]) begin
        if (m_sync == 0) begin a_sync = sync_n_o; e_sync = es; end
        m_sync++;
      end
      if (line_active_o !== ea[0]) begin
        if (m_act == 0) begin a_act = line_active_o; e_act = ea; end
        m_act++;
      end
      if (line_num_o !== el[LN_W-1:0]) begin
        if (m_line == 0) begin a_line = line_num_o; e_line = el; end
        m_line++;
      end
      if (frame_start_o !== ef[0]) begin
        if (m_fs == 0) begin a_fs = frame_start_o; e_fs = ef; end
        m_fs++;
      end
      if (frame_start_o) fs_cnt++;
      if (!sync_n_o && (t % FRAME) >= VCYC && ((t % FRAME) - VCYC) % LINE == 0) begin
        if (last_fall >= 0 && ((t % FRAME) != VCYC) && (t - last_fall) != LINE) begin
          if (fall_bad == 0) begin gap_a = t - last_fall; gap_e = LINE; end
          fall_bad++;
        end
        last_fall = t;
      end
      t++;
    end
  endtask

  task automatic start_run();
    @(negedge clk_i); en_i = 1'b1;
    @(posedge clk_i);
    t = 0;
  endtask

  task automatic test_reset();
    @(negedge clk_i);
    check("R1 reset sync high", sync_n_o === 1'b1, sync_n_o, 1);
    check("R1 reset active low", line_active_o === 1'b0, line_active_o, 0);
    check("R1 reset frame_start low", frame_start_o === 1'b0, frame_start_o, 0);
    check("R1 reset line zero", line_num_o === '0, line_num_o, 0);
    rst_ni = 1'b1;
    @(posedge clk_i);
    t = 0;
  endtask

  task automatic test_vertical();
    clear_stats();
    compare_run(VCYC);
    check("R2/R3/R4 vertical slot sync waveform", m_sync == 0, a_sync, e_sync);
    check("R6 line zero during vertical slots", m_line == 0, a_line, e_line);
    check("R8 no active during vertical slots", m_act == 0, a_act, e_act);
  endtask

  task automatic test_lines();
    clear_stats();
    compare_run(NL * LINE + FRAME);
    check("R5 line sync waveform", m_sync == 0, a_sync, e_sync);
    check("R5 line sync edge spacing", fall_bad == 0, gap_a, gap_e);
    check("R6 line number countdown and wrap", m_line == 0, a_line, e_line);
    check("R7 frame_start timing", m_fs == 0, a_fs, e_fs);
    check("R7 one frame_start per frame", fs_cnt == 2, fs_cnt, 2);
    check("R8 picture window", m_act == 0, a_act, e_act);
  endtask

  task automatic test_disable();
    compare_run(VCYC + 5 * LINE + 20);
    @(negedge clk_i); en_i = 1'b0;
    @(negedge clk_i);
    check("R9 disabled sync high", sync_n_o === 1'b1, sync_n_o, 1);
    check("R9 disabled line zero", line_num_o === '0, line_num_o, 0);
    check("R9 disabled active low", line_active_o === 1'b0, line_active_o, 0);
    repeat (3) @(negedge clk_i);
    check("R9 still parked", sync_n_o === 1'b1 && line_num_o === '0, line_num_o, 0);
    start_run();
    clear_stats();
    compare_run(FRAME + 100);
    check("R9 restart at slot 0 sync", m_sync == 0, a_sync, e_sync);
    check("R9 restart line numbering", m_line == 0, a_line, e_line);
    check("R9 restart frame_start", m_fs == 0, a_fs, e_fs);
  endtask

  initial begin
    #(4 * 200000);
    check("watchdog", 1'b0, 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    test_vertical();
    test_lines();
    test_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule